// File: doc/BRIEF.md
# Dual-Bank Edge/Level Interrupt Controller

This block collects a parameterised set of interrupt sources and drives two processor request lines: a normal request and a fast request. Every source first passes a two-flop synchronizer. It is then qualified either by its level or by a latched edge. The edge can be rising, falling or both, chosen per source by two select masks. The qualified per-source state is called raw status. Both banks see the same raw status. Each bank gates it with its own enable mask, which gives that bank's masked status. Each bank's request line is the registered OR of its masked status.

Software reaches the block over a simple single-cycle register port with address, write enable, write data and registered read data. Enable masks change only through write-one-to-set and write-one-to-clear addresses, so a driver never needs a read-modify-write. Latched edges are released by writing ones to the edge register.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After synchronous reset, every readable register reads zero and both request outputs are low.
- R2: A write to a bank's enable-set address (normal 2, fast 6) sets the enable bits where write data is one and leaves the others unchanged. A read of address 2/3 (normal) or 6/7 (fast) returns that bank's enable mask.
- R3: A write to a bank's enable-clear address (normal 3, fast 7) clears the enable bits where write data is one and leaves the others unchanged.
- R4: A source whose rise-select and fall-select bits are both zero is level detected. Its raw status equals the input after two synchronizer flops, and the request line reflects an input change on the third rising clock edge after the input changes.
- R5: A source with its rise-select bit set (address 9, bit n for source n) latches a one into edge status bit n when its synchronized input goes from 0 to 1.
- R6: A source with its fall-select bit set (address 10) latches on a 1-to-0 change. With both selects set, it latches on either change.
- R7: The edge-status register (address 8, read / write-one-to-clear) clears only the bits written as one. Zero bits have no effect. A level-detected source's raw status is not affected by writes to it.
- R8: If an edge is detected in the same cycle that software clears that bit, the bit stays set.
- R9: Raw status reads at addresses 0 (normal) and 4 (fast) regardless of enables. Masked status at addresses 1 (normal) and 5 (fast) reads raw status AND that bank's enables.
- R10: Each request output (normal, fast) is the registered OR of its own bank's masked status. Enables in one bank never drive the other bank's output.
- R11: The rise-select (9) and fall-select (10) masks are read/write. Read data appears one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Asynchronous interrupt source inputs |
| addr_i | input | 4 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | NSRC | Write data |
| rdata_o | output | NSRC | Registered read data |
| irq_norm_o | output | 1 | Normal-bank interrupt request |
| irq_fast_o | output | 1 | Fast-bank interrupt request |

## Verification
The bench sweeps every source through level, rising, falling and both-edge detection, with each step checked against expected latch contents. A detector that ignored a select bit, or compared the wrong samples, would latch on the wrong transition. It times a level change to the exact request cycle, so a missing or extra synchronizer stage shows up as an early or late request. It lands a clear write on the very cycle an edge is detected, where a clear-wins priority would drop the event. It also writes zero to the clear register and to the enable-clear register, where a plain store instead of a masked update would wipe unrelated bits. Fast-bank checks catch enables leaking between banks.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 4;
  localparam int NBANKS = 2;

  // register word addresses; banks occupy 0..3 and 4..7
  typedef enum logic [ADDR_W-1:0] {
    A_NRM_RAW  = 4'd0,
    A_NRM_STAT = 4'd1,
    A_NRM_SET  = 4'd2,
    A_NRM_CLR  = 4'd3,
    A_FST_RAW  = 4'd4,
    A_FST_STAT = 4'd5,
    A_FST_SET  = 4'd6,
    A_FST_CLR  = 4'd7,
    A_EDGE     = 4'd8,
    A_RISE     = 4'd9,
    A_FALL     = 4'd10
  } reg_addr_e;

  // offsets inside a bank window
  localparam logic [1:0] BOFS_RAW  = 2'd0;
  localparam logic [1:0] BOFS_STAT = 2'd1;
  localparam logic [1:0] BOFS_SET  = 2'd2;
  localparam logic [1:0] BOFS_CLR  = 2'd3;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] rise_sel_i,
  input  logic [NSRC-1:0] fall_sel_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] edge_o,
  output logic [NSRC-1:0] raw_o
);
  logic [NSRC-1:0] s_q, prev_q, edge_q;
  logic [NSRC-1:0] rise_hit, fall_hit, hit, edge_mode;

  irqc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (src_i),
    .q_o (s_q)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= s_q;
  end

  always_comb begin
    rise_hit  = s_q & ~prev_q & rise_sel_i;
    fall_hit  = ~s_q & prev_q & fall_sel_i;
    hit       = rise_hit | fall_hit;
    edge_mode = rise_sel_i | fall_sel_i;
  end

  // a new event outranks a clear landing in the same cycle
  always_ff @(posedge clk) begin
    if (rst) edge_q <= '0;
    else     edge_q <= (edge_q & ~clr_i) | hit;
  end

  assign edge_o = edge_q;
  assign raw_o  = (edge_mode & edge_q) | (~edge_mode & s_q);

  a_r5_rise_latch: assert property (@(posedge clk) disable iff (rst)
    (|rise_hit) |=> ((edge_q & $past(rise_hit)) == $past(rise_hit)));

  a_r6_fall_latch: assert property (@(posedge clk) disable iff (rst)
    (|fall_hit) |=> ((edge_q & $past(fall_hit)) == $past(fall_hit)));

  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (($past(edge_q) & ~edge_q & ~$past(clr_i)) == '0));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|(hit & clr_i)) |=> ((edge_q & $past(hit & clr_i)) == $past(hit & clr_i)));
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] raw_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] stat_o,
  output logic            irq_o
);
  logic [NSRC-1:0] en_q;
  logic            irq_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | set_i) & ~clr_i;
  end

  assign stat_o = raw_i & en_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |stat_o;
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;

  a_r2_set_bits: assert property (@(posedge clk) disable iff (rst)
    (|(set_i & ~clr_i)) |=> ((en_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

  a_r3_clr_bits: assert property (@(posedge clk) disable iff (rst)
    (|clr_i) |=> ((en_q & $past(clr_i)) == '0));

  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_o);
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic              irq_norm_o,
  output logic              irq_fast_o
);
  logic [NSRC-1:0] rise_q, fall_q, edge_w, raw_w, edge_clr;
  logic [NSRC-1:0] en_w   [NBANKS];
  logic [NSRC-1:0] stat_w [NBANKS];
  logic [NSRC-1:0] set_w  [NBANKS];
  logic [NSRC-1:0] clrb_w [NBANKS];
  logic [NBANKS-1:0] irq_w;
  logic [NSRC-1:0] rd_mux, rdata_q;

  // mode select registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_RISE) rise_q <= wdata_i;
      if (addr_i == A_FALL) fall_q <= wdata_i;
    end
  end

  assign edge_clr = (we_i && addr_i == A_EDGE) ? wdata_i : '0;

  irqc_detect #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk        (clk),
    .rst        (rst),
    .src_i      (src_i),
    .rise_sel_i (rise_q),
    .fall_sel_i (fall_q),
    .clr_i      (edge_clr),
    .edge_o     (edge_w),
    .raw_o      (raw_w)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic in_win;
    assign in_win    = we_i && !addr_i[3] && (addr_i[2] == 1'(b));
    assign set_w[b]  = (in_win && addr_i[1:0] == BOFS_SET) ? wdata_i : '0;
    assign clrb_w[b] = (in_win && addr_i[1:0] == BOFS_CLR) ? wdata_i : '0;

    irqc_bank #(.NSRC(NSRC)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_w[b]),
      .clr_i  (clrb_w[b]),
      .raw_i  (raw_w),
      .en_o   (en_w[b]),
      .stat_o (stat_w[b]),
      .irq_o  (irq_w[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (!addr_i[3]) begin
      case (addr_i[1:0])
        BOFS_RAW:  rd_mux = raw_w;
        BOFS_STAT: rd_mux = stat_w[addr_i[2]];
        default:   rd_mux = en_w[addr_i[2]];
      endcase
    end else begin
      case (addr_i)
        A_EDGE:  rd_mux = edge_w;
        A_RISE:  rd_mux = rise_q;
        A_FALL:  rd_mux = fall_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign rdata_o    = rdata_q;
  assign irq_norm_o = irq_w[0];
  assign irq_fast_o = irq_w[1];

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_norm_o && !irq_fast_o && rdata_o == '0));

  a_r11_rise_store: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == A_RISE) |=> (rise_q == $past(wdata_i)));
endmodule

// File: tb/irq_edge_ctrl_test.sv
module irq_edge_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src = '0;
  logic [3:0]    addr = '0;
  logic          we = 1'b0;
  logic [NS-1:0] wdata = '0;
  logic [NS-1:0] rdata;
  logic          irq_n, irq_f;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_edge_ctrl #(.NSRC(NS), .SYNC_STAGES(2)) uut (
    .clk        (clk),
    .rst        (rst),
    .src_i      (src),
    .addr_i     (addr),
    .we_i       (we),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .irq_norm_o (irq_n),
    .irq_fast_o (irq_f)
  );

  task automatic chk(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [NS-1:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [NS-1:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [NS-1:0] v;
    logic [NS-1:0] pats [5];
    pats = '{8'h00, 8'hA5, 8'h5A, 8'hFF, 8'h01};
    waitc(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), v);
      chk("R1 reset readback", v, '0);
    end
    chk("R1 irq_norm after reset", {7'b0, irq_n}, '0);
    chk("R1 irq_fast after reset", {7'b0, irq_f}, '0);

    // R2 / R3 enable set and clear
    wr(4'd2, 8'h05); rd(4'd2, v); chk("R2 set 05", v, 8'h05);
    wr(4'd2, 8'h20); rd(4'd3, v); chk("R2 set keeps others", v, 8'h25);
    wr(4'd2, 8'h00); rd(4'd2, v); chk("R2 zero set no effect", v, 8'h25);
    wr(4'd3, 8'h04); rd(4'd2, v); chk("R3 clear 04", v, 8'h21);
    wr(4'd3, 8'h00); rd(4'd2, v); chk("R3 zero clear no effect", v, 8'h21);
    rd(4'd6, v); chk("R2 fast untouched", v, 8'h00);
    wr(4'd3, 8'hFF); rd(4'd2, v); chk("R3 clear all", v, 8'h00);

    // R4 sync latency: level source 0 enabled in normal bank
    wr(4'd2, 8'h01);
    src = 8'h01;
    @(negedge clk);
    @(negedge clk);
    chk("R4 no request after two edges", {7'b0, irq_n}, 8'h00);
    @(negedge clk);
    chk("R4 request on third edge", {7'b0, irq_n}, 8'h01);
    src = 8'h00; waitc(4);
    chk("R4 request drops with level", {7'b0, irq_n}, 8'h00);
    wr(4'd3, 8'hFF);

    // R9 / R10 level sweep with normal enables 0F
    wr(4'd2, 8'h0F);
    foreach (pats[i]) begin
      src = pats[i]; waitc(5);
      rd(4'd0, v); chk("R4 R9 normal raw", v, pats[i]);
      rd(4'd4, v); chk("R9 fast raw ignores enables", v, pats[i]);
      rd(4'd1, v); chk("R9 normal masked", v, pats[i] & 8'h0F);
      rd(4'd5, v); chk("R9 fast masked", v, 8'h00);
      chk("R10 normal line", {7'b0, irq_n}, {7'b0, |(pats[i] & 8'h0F)});
      chk("R10 fast line stays low", {7'b0, irq_f}, 8'h00);
    end
    src = '0; waitc(4);
    wr(4'd3, 8'hFF);

    // R5 / R6 edge sweep over every source and edge mode
    for (int n = 0; n < NS; n++) begin
      for (int m = 1; m < 4; m++) begin
        logic [NS-1:0] bitn;
        bitn = 8'(1 << n);
        wr(4'd9,  m[0] ? bitn : 8'h00);
        wr(4'd10, m[1] ? bitn : 8'h00);
        src = bitn; waitc(5);
        rd(4'd8, v); chk("R5 R6 after rise", v, m[0] ? bitn : 8'h00);
        src = 8'h00; waitc(5);
        rd(4'd8, v); chk("R5 R6 after fall", v, bitn);
        rd(4'd0, v); chk("R5 raw shows latch", v, bitn);
        wr(4'd8, bitn);
        rd(4'd8, v); chk("R7 clear one", v, 8'h00);
      end
    end

    // R11 select readback
    wr(4'd9, 8'h0A); wr(4'd10, 8'h30);
    rd(4'd9, v);  chk("R11 rise select", v, 8'h0A);
    rd(4'd10, v); chk("R11 fall select", v, 8'h30);

    // R7 zero writes keep latches; level source immune to clears
    src = 8'h0A; waitc(5);
    src = 8'h80; waitc(5);
    rd(4'd8, v); chk("R7 latched pair", v, 8'h0A);
    wr(4'd8, 8'h00);
    rd(4'd8, v); chk("R7 zero write keeps", v, 8'h0A);
    wr(4'd8, 8'h02);
    rd(4'd8, v); chk("R7 clears only written", v, 8'h08);
    wr(4'd8, 8'hFF);
    rd(4'd0, v); chk("R7 level raw unaffected", v, 8'h80);
    src = 8'h00; waitc(4);
    wr(4'd8, 8'hFF);

    // R8 clear colliding with detection
    wr(4'd9, 8'h04); wr(4'd10, 8'h00);
    src = 8'h04;
    @(negedge clk);
    wr(4'd8, 8'h04);
    rd(4'd8, v); chk("R8 event survives same-cycle clear", v, 8'h04);
    wr(4'd8, 8'h04);
    rd(4'd8, v); chk("R8 later clear works", v, 8'h00);
    src = 8'h00; waitc(4);

    // R10 fast bank independence
    wr(4'd9, 8'h80);
    wr(4'd6, 8'h80);
    src = 8'h80; waitc(5);
    chk("R10 fast line high", {7'b0, irq_f}, 8'h01);
    chk("R10 normal line low", {7'b0, irq_n}, 8'h00);
    rd(4'd5, v); chk("R9 fast masked edge", v, 8'h80);
    rd(4'd1, v); chk("R9 normal masked edge", v, 8'h00);
    wr(4'd7, 8'h80); waitc(2);
    chk("R3 R10 fast line drops", {7'b0, irq_f}, 8'h00);
    rd(4'd8, v); chk("R7 latch kept after disable", v, 8'h80);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule